// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the device-side command front end of a four-bank SDRAM. On each rising clock edge it samples the command strobes (chip select, row strobe, column strobe, write enable), the two bank-select bits and the address bus. It turns them into one decoded command per cycle: no-op, activate, read, write, precharge, refresh or mode-register load. For each bank it keeps whether the bank is idle or active and which row is open.

A read or write to an idle bank is rejected and flagged, and so is an activate to a bank that is already open. A read or write that carries the auto-precharge flag closes its bank once the command has been accepted. A low clock enable freezes the whole decoder from the following cycle. If every bank is idle when the clock enable drops, the block also reports power-down.

All outputs are registered. The decoded strobe and its fields appear one clock after the edge that sampled the command. Data strobes, data capture, refresh timing and the storage array are handled elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: A cycle with chip select (`cs_n`) sampled high is a no-op. In the following cycle `cmd_vld`=0, `cmd_err`=0 and `cmd_code`=0, and no bank or mode state changes.
- R2: Command codes on `cmd_code` are: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load. The strobe patterns, written as cs,ras,cas,we, are: 0011 activate, 0010 precharge, 0101 read, 0100 write, 0001 refresh, 0000 mode load, 0111 no-op. An activate opens the bank selected by `ba` and records `addr[11:0]` as its row on `bank_row[12*b +: 12]`.
- R3: An activate to a bank that is already active sets `cmd_err`=1 and `cmd_vld`=0, and the open row is kept.
- R4: For a read or write, `cmd_col` is `addr[7:0]`, `cmd_ap` is `addr[8]` and `cmd_bank` is `ba`. All command outputs are updated one cycle after the sampling edge.
- R5: A read or write to an idle bank sets `cmd_err`=1 and `cmd_vld`=0, and the bank stays idle.
- R6: A read or write accepted with `addr[8]`=1 leaves its bank idle in the following cycle.
- R7: A precharge with `addr[8]`=1 makes all four banks idle. With `addr[8]`=0 it makes only bank `ba` idle.
- R8: Refresh and no-op leave every bank state unchanged. Refresh reports `cmd_vld`=1 and no-op reports `cmd_vld`=0.
- R9: A mode load with `ba`=0 writes `addr` into `mode_reg`, and with `ba`=1 into `ext_mode_reg`. With `ba`=2 or 3 it writes neither register.
- R10: When `cke` is sampled low, the command at that same edge is still executed. Every later edge is frozen: all outputs and all state hold, and commands are ignored. This lasts up to and including the first edge at which `cke` is sampled high again.
- R11: `pwr_down` rises when `cke` is sampled low on an unfrozen edge and all banks are idle after that edge. It stays at 0 if any bank is active. It clears at the first edge that samples `cke` high.
- R12: A synchronous active-low reset (`rst_n`) makes all banks idle and clears both mode registers, all command outputs, the suspension state and `pwr_down`.
- R13: `cmd_vld` and `cmd_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address / op-code bus |
| cmd_vld | output | 1 | Accepted command strobe |
| cmd_err | output | 1 | Rejected illegal access |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Bank of the command |
| cmd_row | output | 12 | Row field |
| cmd_col | output | 8 | Column field |
| cmd_ap | output | 1 | Auto-precharge on read/write |
| bank_active | output | 4 | Per-bank active flag |
| bank_row | output | 48 | Open row of each bank, 12 bits per bank |
| mode_reg | output | 12 | Mode register |
| ext_mode_reg | output | 12 | Extended mode register |
| pwr_down | output | 1 | Power-down indication |

## Verification
Two functions can act at the same clock edge: executing a command and entering suspension. An activate is issued on the very edge that samples `cke` low. The bench expects that activate to take effect and expects the next command, issued while suspended, to leave every output unchanged. Power-down entry and bank closing can also meet at one edge. A precharge-all issued with `cke` low must close every bank and raise `pwr_down` in the same result cycle. An activate on a low-`cke` edge must keep `pwr_down` at 0.

// File: rtl/sdcf_pkg.sv
// Shared command type for the SDRAM command front end.
// Assumes three-bit encoding is sufficient for all decoded commands.
package sdcf_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } sdcf_cmd_e;
endpackage

// File: rtl/sdcf_decode.sv
// Combinational strobe decoder: maps the four active-low strobes to a
// command code. Assumes inputs are already sampled at the clock edge.
module sdcf_decode
    import sdcf_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output sdcf_cmd_e cmd
);
    // Map strobe pattern to command; deselected chip masks everything.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdcf_bank.sv
// One bank's state: idle/active flag plus its open row.
// Assumes open and close requests are already gated by legality and
// suspension; open wins if both arrive together.
module sdcf_bank #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             active,
    output logic [ROW_W-1:0] row
);
    // Track open/idle state and latch the row on open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            row    <= '0;
        end else if (open_req) begin
            active <= 1'b1;
            row    <= row_in;
        end else if (close_req) begin
            active <= 1'b0;
        end
    end
endmodule

// File: rtl/sdcf_mode_reg.sv
// Loadable op-code register used for both mode registers.
// Assumes the load request is already gated by suspension.
module sdcf_mode_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Capture op-code on load; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/sdram_cmd_front.sv
// Device-side SDRAM command front end: decodes sampled strobes, checks
// legality against per-bank state, tracks open rows, mode registers,
// clock-enable suspension and power-down. Assumes ADDR_W covers both the
// row field and the auto-precharge bit.
module sdram_cmd_front
    import sdcf_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 12,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 8,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ADDR_W-1:0]      addr,
    output logic                   cmd_vld,
    output logic                   cmd_err,
    output logic [2:0]             cmd_code,
    output logic [BA_W-1:0]        cmd_bank,
    output logic [ROW_W-1:0]       cmd_row,
    output logic [COL_W-1:0]       cmd_col,
    output logic                   cmd_ap,
    output logic [NBANK-1:0]       bank_active,
    output logic [NBANK*ROW_W-1:0] bank_row,
    output logic [ADDR_W-1:0]      mode_reg,
    output logic [ADDR_W-1:0]      ext_mode_reg,
    output logic                   pwr_down
);
    sdcf_cmd_e        dec;
    logic             susp_q;
    logic             run;
    logic             is_col;
    logic             ap_bit;
    logic             sel_active;
    logic             bad_act;
    logic             bad_col;
    logic             illegal;
    logic             accept;
    logic [NBANK-1:0] open_req;
    logic [NBANK-1:0] close_req;
    logic [NBANK-1:0] next_active;
    logic             ld_mode;
    logic             ld_ext;

    sdcf_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (dec)
    );

    assign run        = ~susp_q;
    assign is_col     = (dec == CMD_RD) || (dec == CMD_WR);
    assign ap_bit     = addr[AP_BIT];
    assign sel_active = bank_active[ba];
    assign bad_act    = (dec == CMD_ACT) && sel_active;
    assign bad_col    = is_col && !sel_active;
    assign illegal    = bad_act || bad_col;
    assign accept     = run && !illegal && (dec != CMD_NOP);

    // Per-bank request generation and state instances.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));
        assign open_req[b]  = accept && (dec == CMD_ACT) && hit;
        assign close_req[b] = accept &&
                              (((dec == CMD_PRE) && (ap_bit || hit)) ||
                               (is_col && ap_bit && hit));
        assign next_active[b] = open_req[b] || (bank_active[b] && !close_req[b]);

        sdcf_bank #(.ROW_W(ROW_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[b]),
            .close_req (close_req[b]),
            .row_in    (addr[ROW_W-1:0]),
            .active    (bank_active[b]),
            .row       (bank_row[b*ROW_W +: ROW_W])
        );
    end

    assign ld_mode = accept && (dec == CMD_MRS) && (ba == BA_W'(0));
    assign ld_ext  = accept && (dec == CMD_MRS) && (ba == BA_W'(1));

    sdcf_mode_reg #(.W(ADDR_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_mode),
        .din   (addr),
        .q     (mode_reg)
    );

    sdcf_mode_reg #(.W(ADDR_W)) u_ext_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_ext),
        .din   (addr),
        .q     (ext_mode_reg)
    );

    // Suspension flag: a low clock enable freezes the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) susp_q <= 1'b0;
        else        susp_q <= ~cke;
    end

    // Power-down: entered on an unfrozen low-enable edge with all banks idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      pwr_down <= 1'b0;
        else if (cke)    pwr_down <= 1'b0;
        else if (run)    pwr_down <= ~|next_active;
    end

    // Registered command outputs, held while suspended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld  <= 1'b0;
            cmd_err  <= 1'b0;
            cmd_code <= CMD_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
            cmd_ap   <= 1'b0;
        end else if (run) begin
            cmd_vld  <= accept;
            cmd_err  <= illegal;
            cmd_code <= dec;
            cmd_bank <= ba;
            cmd_row  <= addr[ROW_W-1:0];
            cmd_col  <= addr[COL_W-1:0];
            cmd_ap   <= is_col && ap_bit;
        end
    end
endmodule

// File: rtl/sdcf_chk.sv
// Property checker for sdram_cmd_front, attached by bind.
module sdcf_chk #(
    parameter int NBANK = 4,
    parameter int BA_W  = 2,
    parameter int W     = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             susp_q,
    input logic             cmd_vld,
    input logic             cmd_err,
    input logic [2:0]       cmd_code,
    input logic [BA_W-1:0]  cmd_bank,
    input logic             cmd_ap,
    input logic [NBANK-1:0] bank_active,
    input logic [W-1:0]     mode_reg,
    input logic             pwr_down
);
    // R13
    vld_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld && cmd_err));

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_code == 3'd1) |-> bank_active[cmd_bank]);

    // R6
    ap_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && (cmd_code == 3'd2 || cmd_code == 3'd3) && cmd_ap)
            |-> !bank_active[cmd_bank]);

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_q |=> ($stable(bank_active) && $stable(cmd_code) && $stable(cmd_vld)));

    // R11
    pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (bank_active == '0));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (bank_active == '0 && mode_reg == '0 && !pwr_down));
endmodule

bind sdram_cmd_front sdcf_chk #(.NBANK(NBANK), .BA_W(BA_W), .W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .susp_q      (susp_q),
    .cmd_vld     (cmd_vld),
    .cmd_err     (cmd_err),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .cmd_ap      (cmd_ap),
    .bank_active (bank_active),
    .mode_reg    (mode_reg),
    .pwr_down    (pwr_down)
);

// File: tb/sdram_cmd_front_test.sv
module sdram_cmd_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        cmd_vld, cmd_err, cmd_ap, pwr_down;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row, mode_reg, ext_mode_reg;
    logic [7:0]  cmd_col;
    logic [3:0]  bank_active;
    logic [47:0] bank_row;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    sdram_cmd_front uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_vld(cmd_vld), .cmd_err(cmd_err), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_ap(cmd_ap), .bank_active(bank_active), .bank_row(bank_row),
        .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg), .pwr_down(pwr_down)
    );

    always #4 clk = ~clk;

    // Vector: cke, strobes{cs,ras,cas,we}, ba, addr | vld, code, err, active
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 4'b0011, 2'd0, 12'h005, 1'b1, 3'd1, 1'b0, 4'b0001}, // R2 act b0
        {1'b1, 4'b0011, 2'd2, 12'hABC, 1'b1, 3'd1, 1'b0, 4'b0101}, // R2 act b2
        {1'b1, 4'b0101, 2'd0, 12'h012, 1'b1, 3'd2, 1'b0, 4'b0101}, // R4 read b0
        {1'b1, 4'b0100, 2'd2, 12'h134, 1'b1, 3'd3, 1'b0, 4'b0001}, // R6 write ap b2
        {1'b1, 4'b0101, 2'd1, 12'h000, 1'b0, 3'd2, 1'b1, 4'b0001}, // R5 read idle
        {1'b1, 4'b0011, 2'd0, 12'h777, 1'b0, 3'd1, 1'b1, 4'b0001}, // R3 re-act
        {1'b1, 4'b1011, 2'd1, 12'h0FF, 1'b0, 3'd0, 1'b0, 4'b0001}, // R1 deselect
        {1'b1, 4'b0001, 2'd0, 12'h000, 1'b1, 3'd5, 1'b0, 4'b0001}, // R8 refresh
        {1'b1, 4'b0111, 2'd3, 12'h000, 1'b0, 3'd0, 1'b0, 4'b0001}, // R8 nop
        {1'b1, 4'b0010, 2'd0, 12'h000, 1'b1, 3'd4, 1'b0, 4'b0000}, // R7 pre b0
        {1'b1, 4'b0011, 2'd1, 12'h0FF, 1'b1, 3'd1, 1'b0, 4'b0010}, // R2 act b1
        {1'b1, 4'b0011, 2'd3, 12'h001, 1'b1, 3'd1, 1'b0, 4'b1010}, // R2 act b3
        {1'b1, 4'b0010, 2'd3, 12'h000, 1'b1, 3'd4, 1'b0, 4'b0010}, // R7 pre b3 only
        {1'b1, 4'b0010, 2'd0, 12'h100, 1'b1, 3'd4, 1'b0, 4'b0000}, // R7 pre all
        {1'b1, 4'b0000, 2'd0, 12'h032, 1'b1, 3'd6, 1'b0, 4'b0000}, // R9 mode
        {1'b1, 4'b0000, 2'd1, 12'h004, 1'b1, 3'd6, 1'b0, 4'b0000}, // R9 ext
        {1'b1, 4'b0000, 2'd2, 12'hFFF, 1'b1, 3'd6, 1'b0, 4'b0000}  // R9 ba2
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at negedge, let one posedge sample, return at next negedge.
    task automatic issue(input logic k, input logic [3:0] s, input logic [1:0] b,
                         input logic [11:0] a);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = s;
        ba = b;
        addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        issue(1'b1, 4'b0111, 2'd0, 12'h000);
        chk("R12 reset active", bank_active, 4'b0000);
        chk("R12 reset vld", cmd_vld, 1'b0);
        chk("R12 reset mode", mode_reg, 12'h000);
        chk("R12 reset pd", pwr_down, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            issue(v[27], v[26:23], v[22:21], v[20:9]);
            chk($sformatf("R2 vec%0d vld", i), cmd_vld, v[8]);
            chk($sformatf("R2 vec%0d code", i), cmd_code, v[7:5]);
            chk($sformatf("R5 vec%0d err", i), cmd_err, v[4]);
            chk($sformatf("R7 vec%0d active", i), bank_active, v[3:0]);
        end
        chk("R9 mode_reg", mode_reg, 12'h032);
        chk("R9 ext_mode_reg", ext_mode_reg, 12'h004);
        chk("R3 row kept b0", bank_row[11:0], 12'h005);
        chk("R2 row b1", bank_row[23:12], 12'h0FF);

        // R4 / R6 field check on a read with auto-precharge
        issue(1'b1, 4'b0011, 2'd3, 12'hABC);
        chk("R2 cmd_row", cmd_row, 12'hABC);
        chk("R2 bank_row b3", bank_row[47:36], 12'hABC);
        issue(1'b1, 4'b0101, 2'd3, 12'h1A7);
        chk("R4 col", cmd_col, 8'hA7);
        chk("R4 ap", cmd_ap, 1'b1);
        chk("R4 bank", cmd_bank, 2'd3);
        chk("R6 bank3 idle", bank_active, 4'b0000);

        // R10 / R11: activate on the low-enable edge executes
        issue(1'b0, 4'b0011, 2'd0, 12'h0AA);
        chk("R10 act at cke edge", bank_active, 4'b0001);
        chk("R11 no pd with open bank", pwr_down, 1'b0);
        issue(1'b0, 4'b0011, 2'd1, 12'h777);
        chk("R10 frozen active", bank_active, 4'b0001);
        chk("R10 frozen bank", cmd_bank, 2'd0);
        chk("R10 frozen vld", cmd_vld, 1'b1);
        issue(1'b1, 4'b0011, 2'd2, 12'h777);
        chk("R10 exit edge frozen", bank_active, 4'b0001);
        chk("R10 exit edge code", cmd_code, 3'd1);
        issue(1'b1, 4'b0111, 2'd0, 12'h000);
        chk("R10 resumed code", cmd_code, 3'd0);
        // R11: precharge-all on low-enable edge enters power-down
        issue(1'b0, 4'b0010, 2'd0, 12'h100);
        chk("R11 idle", bank_active, 4'b0000);
        chk("R11 pd set", pwr_down, 1'b1);
        issue(1'b0, 4'b0011, 2'd1, 12'h000);
        chk("R11 pd held", pwr_down, 1'b1);
        chk("R10 pd frozen act", bank_active, 4'b0000);
        issue(1'b1, 4'b0111, 2'd0, 12'h000);
        chk("R11 pd exit", pwr_down, 1'b0);
        issue(1'b1, 4'b0111, 2'd0, 12'h000);

        // R12: reset mid-run
        issue(1'b1, 4'b0011, 2'd2, 12'h055);
        chk("R2 pre-reset act", bank_active, 4'b0100);
        rst_n = 1'b0;
        issue(1'b1, 4'b0111, 2'd0, 12'h000);
        chk("R12 banks cleared", bank_active, 4'b0000);
        chk("R12 mode cleared", mode_reg, 12'h000);
        chk("R12 ext cleared", ext_mode_reg, 12'h000);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule